// File: doc/BRIEF.md
# Beat Tag Pairing and Error Generator

This block sits behind two tag sources that each time-stamp the rising edges of a slow beat signal: a reference channel and a main channel. Every tag is a value of a free-running counter, delivered with a one-cycle valid. The block turns these tags into two signed error words for the loop filters that follow. The filters themselves are not part of the block.

The phase path pairs one reference tag with one main tag, whichever arrives first. It then reports the main-minus-reference distance folded into one beat period of length N and centred on zero. The period path takes reference tags two at a time and reports how far their spacing falls short of, or exceeds, the nominal beat period N. Each result comes with its own one-cycle strobe. The two paths run independently, so one reference tag can serve both in the same cycle.

Top module: `beat_tag_pair_err`

## Requirements
- R1: While reset is held and in the first cycle after it, both strobes are low and both error words read zero.
- R2: A reference tag and a main tag that are valid in the same cycle are paired at once, and the phase strobe is high in the next cycle.
- R3: When the tags of a pair arrive in different cycles, in either order, the phase strobe is high in the cycle after the tag that completes the pair.
- R4: The phase strobe lasts exactly one cycle. Tags presented during that strobe cycle are dropped and open no new pair.
- R5: While one channel's tag is held and the other is awaited, further tags on the held channel are ignored, and the first held tag is used.
- R6: The phase error is d = (main - reference) mod N. When d > N/2 the reported value is d - N, so the result lies in (-N/2, N/2]. N is a power of two (32768 by default).
- R7: The first reference tag arms the period path. The next reference tag raises the period strobe for one cycle in the following cycle. The tag after that arms again, so intervals are measured on disjoint pairs.
- R8: The period error is N - ((second - first) mod 2^TAG_W), saturated to the signed range of the 16-bit error word (N - 0 = 32768 reads as 32767).
- R9: Both paths act on the same reference tag. The phase strobe and the period strobe may be high in the same cycle, each with its own correct value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_tag_vld | input | 1 | Reference tag valid, one cycle per tag |
| ref_tag | input | TAG_W (16) | Reference channel tag |
| main_tag_vld | input | 1 | Main tag valid, one cycle per tag |
| main_tag | input | TAG_W (16) | Main channel tag |
| phase_err | output | ERR_W (16) | Signed folded phase error, meaningful while phase_err_vld is high |
| phase_err_vld | output | 1 | One-cycle phase result strobe |
| period_err | output | ERR_W (16) | Signed period error, held until the next result |
| period_err_vld | output | 1 | One-cycle period result strobe |

## Verification
The phase result and the period result can fall in the same cycle when the reference tag that completes a pair is also the second tag of a period interval. A directed case reaches this by resetting, spending the first reference tag on a finished pair, and then sending a main tag followed by a reference tag. In the cycle after that reference tag, both strobes are expected high, and each value is compared with its own formula. Random traffic with frequent simultaneous tags then hits the same overlap many times, and every cycle is compared with a model of both state machines kept in the bench.

// File: rtl/btp_pkg.sv
package btp_pkg;

  typedef enum logic [1:0] {
    PH_IDLE      = 2'd0,
    PH_WAIT_REF  = 2'd1,
    PH_WAIT_MAIN = 2'd2,
    PH_OUT       = 2'd3
  } btp_phase_st_e;

  typedef enum logic {
    PR_ARM  = 1'b0,
    PR_MEAS = 1'b1
  } btp_period_st_e;

endpackage

// File: rtl/btp_phase_pair.sv
module btp_phase_pair
  import btp_pkg::*;
#(
  parameter int TAG_W  = 16,
  parameter int BEAT_N = 32768,
  parameter int ERR_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_vld,
  input  logic [TAG_W-1:0]        ref_tag,
  input  logic                    main_vld,
  input  logic [TAG_W-1:0]        main_tag,
  output logic signed [ERR_W-1:0] phase_err,
  output logic                    phase_vld
);

  localparam int NB = $clog2(BEAT_N);
  localparam int HALF_I = BEAT_N / 2;
  localparam logic [NB:0] HALF = (NB+1)'(BEAT_N / 2);
  localparam logic signed [NB+1:0] FULL = (NB+2)'(BEAT_N);

  // fold (m - r) mod N into (-N/2, N/2]
  function automatic logic signed [ERR_W-1:0] fold_phase(
    input logic [TAG_W-1:0] m,
    input logic [TAG_W-1:0] r
  );
    logic [NB-1:0] d;
    logic signed [NB+1:0] s;
    d = NB'(m - r);
    if ({1'b0, d} > HALF) s = $signed({2'b00, d}) - FULL;
    else                  s = $signed({2'b00, d});
    return ERR_W'(s);
  endfunction

  btp_phase_st_e st, st_nxt;
  logic [TAG_W-1:0] lat_ref, lat_main;
  logic take_ref, take_main;
  logic pair_done;

  always_comb begin
    st_nxt    = st;
    take_ref  = 1'b0;
    take_main = 1'b0;
    case (st)
      PH_IDLE: begin
        take_ref  = ref_vld;
        take_main = main_vld;
        if (ref_vld && main_vld) st_nxt = PH_OUT;
        else if (ref_vld)        st_nxt = PH_WAIT_MAIN;
        else if (main_vld)       st_nxt = PH_WAIT_REF;
      end
      PH_WAIT_REF: begin
        take_ref = ref_vld;
        if (ref_vld) st_nxt = PH_OUT;
      end
      PH_WAIT_MAIN: begin
        take_main = main_vld;
        if (main_vld) st_nxt = PH_OUT;
      end
      PH_OUT:  st_nxt = PH_IDLE;
      default: st_nxt = PH_IDLE;
    endcase
  end

  assign pair_done = (st_nxt == PH_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= PH_IDLE;
      lat_ref  <= '0;
      lat_main <= '0;
    end else begin
      st <= st_nxt;
      if (take_ref)  lat_ref  <= ref_tag;
      if (take_main) lat_main <= main_tag;
    end
  end

  assign phase_vld = (st == PH_OUT);
  assign phase_err = fold_phase(lat_main, lat_ref);

  // R4
  ph_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_vld |=> !phase_vld);

  // R4
  ph_drop_in_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_vld && (ref_vld || main_vld)) |=> ($stable(lat_ref) && $stable(lat_main)));

  // R3
  ph_wait_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == PH_WAIT_MAIN && main_vld) || (st == PH_WAIT_REF && ref_vld)) |=> phase_vld);

  // R5
  ph_hold_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_WAIT_MAIN && ref_vld) |=> $stable(lat_ref));

  // R2
  ph_pair_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_done |=> phase_vld);

  // R6
  ph_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_vld |-> ((int'(phase_err) > -HALF_I) && (int'(phase_err) <= HALF_I)));

endmodule

// File: rtl/btp_period_meas.sv
module btp_period_meas
  import btp_pkg::*;
#(
  parameter int TAG_W  = 16,
  parameter int BEAT_N = 32768,
  parameter int ERR_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_vld,
  input  logic [TAG_W-1:0]        ref_tag,
  output logic signed [ERR_W-1:0] period_err,
  output logic                    period_vld
);

  localparam longint EMAX = (longint'(1) <<< (ERR_W - 1)) - 1;
  localparam longint EMIN = -(longint'(1) <<< (ERR_W - 1));

  // N - ((cur - base) mod 2^TAG_W), clamped to the error word
  function automatic logic signed [ERR_W-1:0] period_error(
    input logic [TAG_W-1:0] cur,
    input logic [TAG_W-1:0] base
  );
    logic [TAG_W-1:0] d;
    logic signed [63:0] e;
    d = cur - base;
    e = 64'(BEAT_N) - {{(64-TAG_W){1'b0}}, d};
    if (e > EMAX)      e = EMAX;
    else if (e < EMIN) e = EMIN;
    return ERR_W'(e);
  endfunction

  btp_period_st_e st;
  logic [TAG_W-1:0] base_tag;
  logic meas_fire;

  assign meas_fire = (st == PR_MEAS) && ref_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= PR_ARM;
      base_tag   <= '0;
      period_err <= '0;
      period_vld <= 1'b0;
    end else begin
      period_vld <= 1'b0;
      if (ref_vld) begin
        if (st == PR_ARM) begin
          base_tag <= ref_tag;
          st       <= PR_MEAS;
        end else begin
          period_err <= period_error(ref_tag, base_tag);
          period_vld <= 1'b1;
          st         <= PR_ARM;
        end
      end
    end
  end

  // R7
  pr_strobe_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_fire |=> period_vld);

  // R7
  pr_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_vld |=> !period_vld);

  // R7
  pr_needs_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_vld |-> $past(ref_vld));

  // R8
  pr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_fire && (ref_tag == base_tag) && (longint'(BEAT_N) > EMAX))
      |=> (longint'(period_err) == EMAX));

endmodule

// File: rtl/beat_tag_pair_err.sv
module beat_tag_pair_err #(
  parameter int TAG_W  = 16,
  parameter int BEAT_N = 32768,
  parameter int ERR_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_tag_vld,
  input  logic [TAG_W-1:0]        ref_tag,
  input  logic                    main_tag_vld,
  input  logic [TAG_W-1:0]        main_tag,
  output logic signed [ERR_W-1:0] phase_err,
  output logic                    phase_err_vld,
  output logic signed [ERR_W-1:0] period_err,
  output logic                    period_err_vld
);

  btp_phase_pair #(.TAG_W(TAG_W), .BEAT_N(BEAT_N), .ERR_W(ERR_W)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_vld   (ref_tag_vld),
    .ref_tag   (ref_tag),
    .main_vld  (main_tag_vld),
    .main_tag  (main_tag),
    .phase_err (phase_err),
    .phase_vld (phase_err_vld)
  );

  btp_period_meas #(.TAG_W(TAG_W), .BEAT_N(BEAT_N), .ERR_W(ERR_W)) u_period (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_vld    (ref_tag_vld),
    .ref_tag    (ref_tag),
    .period_err (period_err),
    .period_vld (period_err_vld)
  );

  // R1
  top_reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!phase_err_vld && !period_err_vld));

endmodule

// File: tb/beat_tag_pair_err_tb.sv
`timescale 1ns/1ps
module beat_tag_pair_err_tb_top;

  localparam int TW = 16;
  localparam int NN = 32768;
  localparam int EW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rv = 1'b0, mv = 1'b0;
  logic [TW-1:0] rt = '0, mt = '0;
  logic signed [EW-1:0] pe, qe;
  logic pv, qv;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model state
  int m_ph = 0, m_lr = 0, m_lm = 0, m_pr = 0, m_base = 0;

  always #2.5 clk = ~clk;

  beat_tag_pair_err #(.TAG_W(TW), .BEAT_N(NN), .ERR_W(EW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ref_tag_vld(rv), .ref_tag(rt),
    .main_tag_vld(mv), .main_tag(mt),
    .phase_err(pe), .phase_err_vld(pv),
    .period_err(qe), .period_err_vld(qv)
  );

  function automatic int want_phase(int m, int r);
    int d;
    d = ((m - r) % NN + NN) % NN;
    if (d > NN / 2) d = d - NN;
    return d;
  endfunction

  function automatic int want_period(int cur, int base);
    int d, e;
    d = ((cur - base) % 65536 + 65536) % 65536;
    e = NN - d;
    if (e > 32767) e = 32767;
    if (e < -32768) e = -32768;
    return e;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rv = 0; mv = 0; rt = '0; mt = '0;
    repeat (2) @(negedge clk);
    check("R1", "phase strobe in reset", int'(pv), 0);
    check("R1", "period strobe in reset", int'(qv), 0);
    check("R1", "phase err in reset", int'(pe), 0);
    check("R1", "period err in reset", int'(qe), 0);
    rst_n = 1'b1;
    m_ph = 0; m_lr = 0; m_lm = 0; m_pr = 0; m_base = 0;
    @(negedge clk);
    check("R1", "phase strobe after reset", int'(pv), 0);
    check("R1", "period strobe after reset", int'(qv), 0);
  endtask

  // called at a negedge; applies inputs for one edge and checks at the next negedge
  task automatic cyc(bit r_v, int r_t, bit m_v, int m_t, string req);
    int exp_pv, exp_qv, exp_qe;
    exp_qv = 0; exp_qe = 0;
    case (m_ph)
      0: begin
        if (r_v) m_lr = r_t;
        if (m_v) m_lm = m_t;
        if (r_v && m_v) m_ph = 3;
        else if (r_v)   m_ph = 2;
        else if (m_v)   m_ph = 1;
      end
      1: if (r_v) begin m_lr = r_t; m_ph = 3; end
      2: if (m_v) begin m_lm = m_t; m_ph = 3; end
      default: m_ph = 0;
    endcase
    exp_pv = (m_ph == 3) ? 1 : 0;
    if (r_v) begin
      if (m_pr == 0) begin
        m_base = r_t; m_pr = 1;
      end else begin
        exp_qv = 1; exp_qe = want_period(r_t, m_base); m_pr = 0;
      end
    end
    rv = r_v; rt = TW'(r_t); mv = m_v; mt = TW'(m_t);
    @(posedge clk);
    @(negedge clk);
    rv = 0; mv = 0;
    check(req, "phase strobe", int'(pv), exp_pv);
    if (exp_pv == 1) check(req, "phase value", int'(pe), want_phase(m_lm, m_lr));
    check(req, "period strobe", int'(qv), exp_qv);
    if (exp_qv == 1) check(req, "period value", int'(qe), exp_qe);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240125));
    do_reset();

    // R2 simultaneous pair
    cyc(1, 100, 1, 300, "R2");
    // R4 tags during the strobe cycle are dropped
    cyc(1, 5, 1, 9, "R4");
    cyc(0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 0, "R4");
    // R3 reference first, then main
    cyc(1, 1000, 0, 0, "R3");
    cyc(0, 0, 0, 0, "R3");
    cyc(0, 0, 1, 1234, "R3");
    cyc(0, 0, 0, 0, "R3");
    // R3 main first, then reference
    cyc(0, 0, 1, 50, "R3");
    cyc(0, 0, 0, 0, "R3");
    cyc(1, 80, 0, 0, "R3");
    cyc(0, 0, 0, 0, "R3");
    // R5 repeated reference tag while waiting for main
    cyc(1, 10, 0, 0, "R5");
    cyc(1, 20, 0, 0, "R5");
    cyc(0, 0, 1, 30, "R5");
    cyc(0, 0, 0, 0, "R5");
    // R6 fold corners
    cyc(1, 50, 1, 50 + NN / 2, "R6");
    cyc(0, 0, 0, 0, "R6");
    cyc(1, 50, 1, 51 + NN / 2, "R6");
    cyc(0, 0, 0, 0, "R6");
    cyc(1, 10, 1, 5, "R6");
    cyc(0, 0, 0, 0, "R6");
    cyc(1, 100, 1, 40000, "R6");
    cyc(0, 0, 0, 0, "R6");

    // R7 / R8 period from a known armed state
    do_reset();
    cyc(1, 500, 0, 0, "R7");
    cyc(0, 0, 0, 0, "R7");
    cyc(1, 500, 0, 0, "R8");
    cyc(1, 1000, 0, 0, "R7");
    cyc(1, 1000 + NN + 5, 0, 0, "R8");
    cyc(1, 65530, 0, 0, "R7");
    cyc(1, 10, 0, 0, "R8");
    cyc(0, 0, 0, 0, "R7");

    // R9 both strobes in the same cycle
    do_reset();
    cyc(1, 100, 0, 0, "R9");
    cyc(0, 0, 1, 150, "R9");
    cyc(0, 0, 0, 0, "R9");
    cyc(0, 0, 1, 900, "R9");
    cyc(1, 100 + NN - 4, 0, 0, "R9");
    cyc(0, 0, 0, 0, "R9");

    // random mix of both paths
    for (int i = 0; i < 4000; i++) begin
      bit a, b;
      int ta, tb;
      a = ($urandom % 3) == 0;
      b = ($urandom % 3) == 0;
      ta = int'($urandom % 65536);
      tb = (($urandom % 4) == 0) ? (ta + NN / 2 + int'($urandom % 3) - 1) % 65536
                                 : int'($urandom % 65536);
      cyc(a, ta, b, tb, "R9");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule